// File: doc/BRIEF.md
# Level-Masked Priority Interrupt Controller

This block gathers interrupt requests for a small processor and hands it one vector at a time. Eight maskable request lines sit at fixed priority levels 1 (most urgent) to 8. Next to them come a watchdog line and two urgent lines (non-maskable and illegal-opcode) that ignore every enable. A rising edge on any line sets a sticky pending bit. A combinational arbiter picks the winner among the pending bits. A two-state control machine then registers the winner's 16-bit vector and raises a request strobe toward the CPU.

Maskable requests pass through two filters. The first is a global enable input. The second is a 3-bit level threshold, which is registered inside the block. Threshold codes 000 and 001 admit every level. A code n from 010 to 111 admits only levels 1 through 9 − n. The CPU answers with an acknowledge pulse that carries the vector it is serving. That pulse clears the matching pending bit and, when it matches the held vector, ends the request.

The control machine has two states. In IDLE it waits; when the arbiter reports a winner it takes the *grant* transition to HOLD, loading the vector and raising the strobe. In HOLD the vector is frozen; an acknowledge whose vector equals the held one takes the *retire* transition back to IDLE, dropping the strobe.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: While reset is low and after its release, the strobe is low. Reset clears all pending bits and sets the registered level threshold to 000.
- R2: A pending bit is set only by a low-to-high transition of its line. A line that stays high after its request is acknowledged does not raise a new request until it falls and rises again.
- R3: Among admitted maskable requests, the lowest level number wins. Vectors for levels 1 to 8 are 1000h, 1002h, 1006h, 1008h, 100Eh, 1012h, 1016h and 101Ah. Line index k of `irq_lvl_i` is level k+1.
- R4: Threshold codes 000 and 001 admit all eight levels.
- R5: A threshold code n in 010..111 admits only levels 1 to 9 − n. Blocked requests stay pending.
- R6: With `gie_i` low, no maskable request is presented, but its pending bit is kept. The non-maskable lines are not affected by `gie_i`.
- R7: Non-maskable and illegal-opcode requests (vector 101Eh) win over the watchdog (vector 101Ch), and the watchdog wins over every maskable level. Neither the threshold nor `gie_i` affects these three.
- R8: Timing and hold behaviour. A line rising before clock edge k gives a strobe after edge k+1. The vector stays stable while the strobe is high, even if a more urgent request arrives.
- R9: An acknowledge clears every pending bit whose vector equals `ack_vec_i`, so 101Eh clears both urgent sources. If `ack_vec_i` equals the held vector, the strobe drops after that edge. An acknowledge with any other vector leaves the strobe and vector unchanged.
- R10: A change of `mask_i` affects arbitration one clock later than a change of `gie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lvl_i | input | 8 | Maskable request lines, bit k = level k+1 |
| irq_wdt_i | input | 1 | Watchdog overflow request |
| irq_nmi_i | input | 1 | Non-maskable request |
| irq_ill_i | input | 1 | Illegal-opcode request |
| mask_i | input | 3 | Level threshold code |
| gie_i | input | 1 | Global enable for maskable requests |
| ack_i | input | 1 | Acknowledge pulse from the CPU |
| ack_vec_i | input | 16 | Vector being acknowledged |
| req_o | output | 1 | Interrupt request strobe (registered) |
| vec_o | output | 16 | Vector address (registered, valid while `req_o`) |

## Verification
A line edge shows up as a strobe two clock edges later: one edge to set the pending bit and one for the grant. A retire drops the strobe one edge after the acknowledge, and the next winner can be granted on the following edge. A threshold change needs one extra edge, while an enable change needs none. The bench drives every input on the falling edge and keeps a bench-side cycle model that advances on each rising edge. Each output is compared on the falling edge, and the directed checks wait exactly these edge counts before sampling.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int N_LVL   = 8;
    localparam int SRC_WDT = N_LVL;
    localparam int SRC_NMI = N_LVL + 1;
    localparam int SRC_ILL = N_LVL + 2;
    localparam int N_SRC   = N_LVL + 3;
    localparam int VEC_W   = 16;
    localparam int MASK_W  = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ctl_state_e;

    // vector address for each source index
    function automatic logic [VEC_W-1:0] src_vec(input int idx);
        logic [VEC_W-1:0] v;
        case (idx)
            0:       v = 16'h1000;
            1:       v = 16'h1002;
            2:       v = 16'h1006;
            3:       v = 16'h1008;
            4:       v = 16'h100E;
            5:       v = 16'h1012;
            6:       v = 16'h1016;
            7:       v = 16'h101A;
            SRC_WDT: v = 16'h101C;
            default: v = 16'h101E;
        endcase
        return v;
    endfunction

    // highest level number admitted by a threshold code
    function automatic int lvl_limit(input logic [MASK_W-1:0] m);
        int lim;
        if (m <= 3'd1) lim = N_LVL;
        else           lim = 9 - int'(m);
        return lim;
    endfunction

endpackage

// File: rtl/lvl_irq_pend.sv
module lvl_irq_pend
    import lvl_irq_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] prev_q;
    logic [N-1:0] pend_q;

    for (genvar g = 0; g < N; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                pend_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= line_i[g];
                if (line_i[g] && !prev_q[g]) pend_q[g] <= 1'b1;
                else if (clr_i[g])           pend_q[g] <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb
    import lvl_irq_pkg::*;
(
    input  logic [N_SRC-1:0]  pend_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              gie_i,
    output logic              valid_o,
    output logic [VEC_W-1:0]  vec_o
);

    int lim;

    always_comb begin
        lim     = lvl_limit(mask_i);
        valid_o = 1'b0;
        vec_o   = '0;
        if (gie_i) begin
            for (int i = N_LVL - 1; i >= 0; i--) begin
                if (pend_i[i] && (i < lim)) begin
                    valid_o = 1'b1;
                    vec_o   = src_vec(i);
                end
            end
        end
        if (pend_i[SRC_WDT]) begin
            valid_o = 1'b1;
            vec_o   = src_vec(SRC_WDT);
        end
        if (pend_i[SRC_NMI] || pend_i[SRC_ILL]) begin
            valid_o = 1'b1;
            vec_o   = src_vec(SRC_NMI);
        end
    end

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LVL-1:0]  irq_lvl_i,
    input  logic              irq_wdt_i,
    input  logic              irq_nmi_i,
    input  logic              irq_ill_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              gie_i,
    input  logic              ack_i,
    input  logic [VEC_W-1:0]  ack_vec_i,
    output logic              req_o,
    output logic [VEC_W-1:0]  vec_o
);

    ctl_state_e         state_q, state_n;
    logic [MASK_W-1:0]  mask_q;
    logic [N_SRC-1:0]   lines;
    logic [N_SRC-1:0]   clr;
    logic [N_SRC-1:0]   pend_q;
    logic               win_valid;
    logic [VEC_W-1:0]   win_vec;
    logic [VEC_W-1:0]   vec_q;
    logic               req_q;
    logic               retire;

    assign lines = {irq_ill_i, irq_nmi_i, irq_wdt_i, irq_lvl_i};

    for (genvar g = 0; g < N_SRC; g++) begin : g_clr
        assign clr[g] = ack_i && (ack_vec_i == src_vec(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_i;
    end

    lvl_irq_pend #(.N(N_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (lines),
        .clr_i  (clr),
        .pend_o (pend_q)
    );

    lvl_irq_arb u_arb (
        .pend_i  (pend_q),
        .mask_i  (mask_q),
        .gie_i   (gie_i),
        .valid_o (win_valid),
        .vec_o   (win_vec)
    );

    assign retire = ack_i && (ack_vec_i == vec_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // transitions: grant (IDLE->HOLD), retire (HOLD->IDLE)
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (win_valid) state_n = ST_HOLD;
            ST_HOLD: if (retire)    state_n = ST_IDLE;
            default:                state_n = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            vec_q <= '0;
        end else begin
            req_q <= (state_n == ST_HOLD);
            if (state_q == ST_IDLE && win_valid) vec_q <= win_vec;
        end
    end

    assign req_o = req_q;
    assign vec_o = vec_q;

endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk
    import lvl_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_o,
    input logic [VEC_W-1:0]  vec_o,
    input logic              ack_i,
    input logic [VEC_W-1:0]  ack_vec_i,
    input logic              gie_i,
    input logic [MASK_W-1:0] mask_q,
    input logic [N_SRC-1:0]  pend
);

    function automatic int lvl_of(input logic [VEC_W-1:0] v);
        int l;
        l = 0;
        for (int i = 0; i < N_LVL; i++) if (v == src_vec(i)) l = i + 1;
        return l;
    endfunction

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !(ack_i && ack_vec_i == vec_o) |=> req_o && $stable(vec_o));

    p_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && ack_i && ack_vec_i == vec_o |=> !req_o);

    p_vec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (lvl_of(vec_o) != 0) || vec_o == 16'h101C || vec_o == 16'h101E);

    p_gie_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) && lvl_of(vec_o) != 0 |-> $past(gie_i));

    p_level_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) && lvl_of(vec_o) != 0 |-> lvl_of(vec_o) <= lvl_limit($past(mask_q)));

    p_urgent_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) && $past(pend[SRC_NMI] || pend[SRC_ILL]) |-> vec_o == 16'h101E);

endmodule

bind lvl_irq_ctrl lvl_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_o     (req_o),
    .vec_o     (vec_o),
    .ack_i     (ack_i),
    .ack_vec_i (ack_vec_i),
    .gie_i     (gie_i),
    .mask_q    (mask_q),
    .pend      (pend_q)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] lines = '0;
    logic [2:0]  mask = '0;
    logic        gie = 1'b1;
    logic        ack = 1'b0;
    logic [15:0] ackv = '0;
    logic        req_o;
    logic [15:0] vec_o;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    always #10 clk = ~clk;

    lvl_irq_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lvl_i (lines[7:0]),
        .irq_wdt_i (lines[8]),
        .irq_nmi_i (lines[9]),
        .irq_ill_i (lines[10]),
        .mask_i    (mask),
        .gie_i     (gie),
        .ack_i     (ack),
        .ack_vec_i (ackv),
        .req_o     (req_o),
        .vec_o     (vec_o)
    );

    function automatic logic [15:0] exp_vec(input int i);
        logic [15:0] t [11];
        t = '{16'h1000, 16'h1002, 16'h1006, 16'h1008, 16'h100E, 16'h1012,
              16'h1016, 16'h101A, 16'h101C, 16'h101E, 16'h101E};
        return t[i];
    endfunction

    function automatic logic [16:0] exp_win(input logic [10:0] p, input logic [2:0] m,
                                            input logic g);
        int lim;
        lim = (m < 3'd2) ? 8 : 9 - int'(m);
        if (p[9] || p[10]) return {1'b1, 16'h101E};
        if (p[8])          return {1'b1, 16'h101C};
        if (g) for (int i = 0; i < 8; i++)
            if (p[i] && i < lim) return {1'b1, exp_vec(i)};
        return '0;
    endfunction

    // bench-side cycle model
    logic [10:0] m_prev, m_pend;
    logic [2:0]  m_mask;
    logic        m_hold;
    logic [15:0] m_vec;

    always @(posedge clk) begin
        logic [16:0] w;
        logic [10:0] c;
        if (!rst_n) begin
            m_prev = '0; m_pend = '0; m_mask = '0; m_hold = 1'b0; m_vec = '0;
        end else begin
            w = exp_win(m_pend, m_mask, gie);
            if (!m_hold && w[16]) begin m_hold = 1'b1; m_vec = w[15:0]; end
            else if (m_hold && ack && ackv == m_vec) m_hold = 1'b0;
            for (int i = 0; i < 11; i++) c[i] = ack && (ackv == exp_vec(i));
            m_pend = (m_pend & ~c) | (lines & ~m_prev);
            m_prev = lines;
            m_mask = mask;
        end
    end

    always @(negedge clk) begin
        if (rst_n && model_on) begin
            checks++;
            if (req_o !== m_hold || (m_hold && vec_o !== m_vec)) begin
                errors++;
                $display("FAIL R3/R8 model: req=%0b vec=%h expected req=%0b vec=%h",
                         req_o, vec_o, m_hold, m_vec);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic er, input logic [15:0] ev);
        checks++;
        if (req_o !== er || (er && vec_o !== ev)) begin
            errors++;
            $display("FAIL %s: req=%0b vec=%h expected req=%0b vec=%h",
                     tag, req_o, vec_o, er, ev);
        end
    endtask

    task automatic do_ack(input logic [15:0] v);
        ack = 1'b1; ackv = v;
        cyc(1);
        ack = 1'b0;
    endtask

    task automatic pulse(input int i);
        lines[i] = 1'b1; cyc(1); lines[i] = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not end");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        expect_out("R1 strobe low in reset", 1'b0, 16'h0);
        rst_n = 1'b1;
        cyc(1);
        model_on = 1'b1;
        expect_out("R1 strobe low after reset", 1'b0, 16'h0);

        // R8 timing: rise before edge k, strobe after k+1
        lines[3] = 1'b1;
        cyc(1); expect_out("R8 not yet after one edge", 1'b0, 16'h0);
        cyc(1); expect_out("R8 UART level presented", 1'b1, 16'h1008);
        lines[3] = 1'b0;
        pulse(0);
        cyc(1); expect_out("R8 held vector stable", 1'b1, 16'h1008);
        do_ack(16'h1234);
        expect_out("R9 foreign ack ignored", 1'b1, 16'h1008);
        do_ack(16'h1008);
        expect_out("R9 retire drops strobe", 1'b0, 16'h0);
        cyc(1); expect_out("R3 DMA served next", 1'b1, 16'h1000);
        do_ack(16'h1000);
        cyc(1); expect_out("R9 nothing left", 1'b0, 16'h0);

        // R2 sticky edge
        lines[5] = 1'b1;
        cyc(2); expect_out("R2 timer1 presented", 1'b1, 16'h1012);
        do_ack(16'h1012);
        cyc(3); expect_out("R2 no retrigger while high", 1'b0, 16'h0);
        lines[5] = 1'b0; cyc(1);
        lines[5] = 1'b1;
        cyc(2); expect_out("R2 new edge retriggers", 1'b1, 16'h1012);
        lines[5] = 1'b0;
        do_ack(16'h1012);

        // R3/R4 simultaneous at threshold 000
        lines[2] = 1'b1; lines[4] = 1'b1; lines[7] = 1'b1;
        cyc(1); lines = '0;
        cyc(1); expect_out("R3 level3 first", 1'b1, 16'h1006);
        do_ack(16'h1006);
        cyc(1); expect_out("R3 level5 second", 1'b1, 16'h100E);
        do_ack(16'h100E);
        cyc(1); expect_out("R4 level8 admitted at 000", 1'b1, 16'h101A);
        do_ack(16'h101A);

        // R5/R10/R4 threshold
        mask = 3'd7; cyc(2);
        pulse(2);
        cyc(2); expect_out("R5 level3 blocked at 111", 1'b0, 16'h0);
        pulse(1);
        cyc(1); expect_out("R5 level2 admitted at 111", 1'b1, 16'h1002);
        do_ack(16'h1002);
        cyc(1); expect_out("R5 blocked stays pending", 1'b0, 16'h0);
        mask = 3'd1;
        cyc(1); expect_out("R10 threshold lags one cycle", 1'b0, 16'h0);
        cyc(1); expect_out("R4 001 admits level3", 1'b1, 16'h1006);
        do_ack(16'h1006);
        mask = 3'd2; cyc(2);
        pulse(7);
        cyc(2); expect_out("R5 level8 blocked at 010", 1'b0, 16'h0);
        pulse(6);
        cyc(1); expect_out("R5 level7 admitted at 010", 1'b1, 16'h1016);
        do_ack(16'h1016);
        mask = 3'd0;
        cyc(2); expect_out("R4 level8 released at 000", 1'b1, 16'h101A);
        do_ack(16'h101A);

        // R6/R7
        gie = 1'b0;
        pulse(0);
        cyc(2); expect_out("R6 gie low blocks DMA", 1'b0, 16'h0);
        mask = 3'd7;
        lines[9] = 1'b1; lines[10] = 1'b1;
        cyc(1); lines = '0;
        cyc(1); expect_out("R7 urgent ignores gie and mask", 1'b1, 16'h101E);
        do_ack(16'h101E);
        cyc(2); expect_out("R9 shared vector clears both", 1'b0, 16'h0);
        pulse(8);
        cyc(1); expect_out("R7 watchdog ignores gie", 1'b1, 16'h101C);
        do_ack(16'h101C);
        gie = 1'b1;
        cyc(1); expect_out("R6 DMA kept pending", 1'b1, 16'h1000);
        do_ack(16'h1000);
        mask = 3'd0;
        lines[8] = 1'b1; lines[9] = 1'b1; lines[3] = 1'b1;
        cyc(1); lines = '0;
        cyc(1); expect_out("R7 urgent before watchdog", 1'b1, 16'h101E);
        do_ack(16'h101E);
        cyc(1); expect_out("R7 watchdog before maskable", 1'b1, 16'h101C);
        do_ack(16'h101C);
        cyc(1); expect_out("R7 maskable last", 1'b1, 16'h1008);
        do_ack(16'h1008);

        // R1 reset clears pending
        gie = 1'b0;
        pulse(4);
        cyc(1);
        rst_n = 1'b0; cyc(2);
        expect_out("R1 strobe low in second reset", 1'b0, 16'h0);
        rst_n = 1'b1; gie = 1'b1;
        cyc(3); expect_out("R1 pending cleared by reset", 1'b0, 16'h0);

        // random phase, checked by the cycle model
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < 11; i++)
                if ($urandom % 16 == 0) lines[i] = ~lines[i];
            if ($urandom % 64 == 0) mask = 3'($urandom);
            if ($urandom % 32 == 0) gie = ~gie;
            if (req_o && $urandom % 4 == 0) begin
                ack = 1'b1;
                ackv = ($urandom % 8 == 0) ? exp_vec(int'($urandom % 11)) : vec_o;
            end else begin
                ack = 1'b0;
            end
            cyc(1);
        end
        ack = 1'b0;
        cyc(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule